// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block counts hardware events for profiling. It holds a set of general event counters, four by default and never more than 31, plus one dedicated cycle counter. Each general counter has an event-type field that selects which numbered event it adds up. Event producers drive per-cycle increment amounts on a set of source lanes. A parameter gives each lane an event ID, and lanes that share an ID are summed into one event. A software increment event and a core-cycle event are built in. Each counter is 64 bits wide and can signal overflow at 32 or 64 bits. Overflows set sticky status bits, which can raise a level interrupt.

Software reaches the block through a plain register port. The write enable, address and write data are sampled on the rising clock edge. Read data is combinational from the address. There is no stream traffic, so no valid/ready handshake applies. Every input is taken as offered, each cycle.

A per-counter filter input stands in for privilege and security filtering. A configuration with more than 31 general counters is rejected at elaboration.

Top module: `pmu_top`

## Requirements
- R1: After reset every counter, the overflow status, the enables, the control bits and the event types read zero, and `irq` is low.
- R2: A counter adds only when the global enable (control bit 0, address 0x00) is set, its own bit in the count-enable register (address 0x01) is set, and its `ev_filtered` bit is low. The cycle counter uses bit NUM_CTR of every per-counter register.
- R3: General counter i adds, each cycle, the sum of the lanes whose parameter ID equals its event type. The 64-bit value is read and written at address 0x10+i. An event type that no source drives leaves the counter unchanged.
- R4: Writing event type i (address 0x50+i, bits 7:0) with an ID different from the current one clears counter i in the same cycle. Writing the same ID leaves the value alone.
- R5: Writing the software-increment register (address 0x04) adds exactly 1 to each counting general counter whose bit is set in the written value and whose event type is 0x00. This register reads 0.
- R6: The cycle counter (64-bit view at 0x07, low-32 view at 0x08) counts `cyc_tick`. Its event type at 0x09 always reads 0x11, and writes there are ignored. A general counter set to 0x11 also counts `cyc_tick`.
- R7: When the divide bit (control bit 2) is set, accepted cycle ticks build up in a 6-bit remainder. The cycle counter advances by 1 on each carry out of it. The remainder clears whenever a control write changes the divide bit.
- R8: Overflow is flagged when the amount added exceeds the distance to all-ones. That distance is taken over 64 bits when the counter's width flag (address 0x06) is set, and over the low 32 bits otherwise. Overflow sets the counter's bit in the status register (0x02). The low-32 views (0x30+i, 0x08) return bits 31:0.
- R9: `irq` is high exactly when some status bit is set whose interrupt-enable bit (0x03) is also set. Status bits are cleared by writing ones. A new overflow in the same cycle wins over the clear.
- R10: After software loads a counter value, the first nonzero accepted increment that follows is dropped, and the drop flag then clears. An increment arriving in the write cycle itself is not counted.
- R11: Writing control with bit 1 set clears the cycle counter to zero. It then drops the next increment, as R10 describes.
- R12: The common-event bitmap (0x05, read-only) has bit n set for each implemented event n below 0x20. These are 0x00, 0x11 and each lane ID below 0x20. With the default map this reads 0x00020141.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_delta | input | NUM_SRC*DW | Per-lane increment amounts; lane s occupies bits s*DW+DW-1:s*DW |
| cyc_tick | input | 1 | Core-cycle event, one per active cycle |
| ev_filtered | input | NUM_CTR+1 | Per-counter filter; bit NUM_CTR is the cycle counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that register writes are single-cycle strobes with a stable address and data. They also assume `ev_filtered` and `cyc_tick` are plain levels that need no protocol. The stimulus therefore changes inputs only on the falling edge, issues at most one write per cycle, and restricts addresses to the implemented map, except for a few deliberate reads of unused locations. Event types are drawn from a small set that covers the software, cycle, mapped, unmapped and out-of-bitmap IDs. Loaded values sit just below the 32-bit and 64-bit limits so that overflows arise often.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int AW = 7;
  localparam logic [AW-1:0] A_CTRL    = 7'h00;
  localparam logic [AW-1:0] A_CEN     = 7'h01;
  localparam logic [AW-1:0] A_OVF     = 7'h02;
  localparam logic [AW-1:0] A_INTEN   = 7'h03;
  localparam logic [AW-1:0] A_SWINC   = 7'h04;
  localparam logic [AW-1:0] A_CEID    = 7'h05;
  localparam logic [AW-1:0] A_WIDE    = 7'h06;
  localparam logic [AW-1:0] A_CYC     = 7'h07;
  localparam logic [AW-1:0] A_CYC32   = 7'h08;
  localparam logic [AW-1:0] A_CYCTYPE = 7'h09;
  localparam logic [AW-1:0] A_VAL     = 7'h10;
  localparam logic [AW-1:0] A_LO      = 7'h30;
  localparam logic [AW-1:0] A_TYPE    = 7'h50;
  localparam logic [7:0] EV_SOFT  = 8'h00;
  localparam logic [7:0] EV_CYCLE = 8'h11;
  localparam int CW = 64;
endpackage

// File: rtl/pmu_prescale.sv
module pmu_prescale (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       div_en,
  input  logic       div_toggle,
  input  logic       tick,
  output logic       step,
  output logic [5:0] rem
);
  logic [5:0] rem_q;

  assign step = div_en ? (tick & (&rem_q)) : tick;
  assign rem  = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               rem_q <= '0;
    else if (div_toggle)      rem_q <= '0;
    else if (div_en && tick)  rem_q <= rem_q + 6'd1;
  end
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int NUM_SRC = 4,
  parameter int DW = 4,
  parameter int SUMW = 7,
  parameter logic [NUM_SRC*8-1:0] SRC_EVT = 32'h40080806
) (
  input  logic [7:0]          evt_id,
  input  logic [NUM_SRC*DW-1:0] src_delta,
  input  logic                cyc_tick,
  input  logic                sw_bit,
  output logic [SUMW-1:0]     delta
);
  import pmu_pkg::*;

  always_comb begin
    delta = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (SRC_EVT[s*8 +: 8] == evt_id)
        delta = delta + SUMW'(src_delta[s*DW +: DW]);
    end
    if (evt_id == EV_CYCLE) delta = delta + SUMW'(cyc_tick);
    if (evt_id == EV_SOFT)  delta = delta + SUMW'(sw_bit);
  end
endmodule

// File: rtl/pmu_ctr.sv
module pmu_ctr #(
  parameter int DLW = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  count_en,
  input  logic [DLW-1:0]        delta,
  input  logic                  wide,
  input  logic                  wr_en,
  input  logic [pmu_pkg::CW-1:0] wr_val,
  input  logic                  clr,
  output logic [pmu_pkg::CW-1:0] value,
  output logic                  ovf_set
);
  import pmu_pkg::*;

  logic [CW-1:0] val_q;
  logic          skip_q;
  logic [CW-1:0] room;
  logic [CW-1:0] dext;
  logic          act;

  assign dext  = {{(CW-DLW){1'b0}}, delta};
  assign room  = wide ? ~val_q : {32'h0, ~val_q[31:0]};
  assign act   = count_en && (delta != '0);
  assign ovf_set = act && !skip_q && !wr_en && !clr && (dext > room);
  assign value = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      skip_q <= 1'b0;
    end else if (wr_en) begin
      val_q  <= wr_val;
      skip_q <= 1'b1;
    end else if (clr) begin
      val_q  <= '0;
    end else if (act) begin
      if (skip_q) skip_q <= 1'b0;
      else        val_q  <= val_q + dext;
    end
  end
endmodule

// File: rtl/pmu_top.sv
module pmu_top #(
  parameter int NUM_CTR = 4,
  parameter int NUM_SRC = 4,
  parameter int DW = 4,
  parameter logic [NUM_SRC*8-1:0] SRC_EVT = 32'h40080806
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC*DW-1:0]   ev_delta,
  input  logic                    cyc_tick,
  input  logic [NUM_CTR:0]        ev_filtered,
  input  logic                    reg_we,
  input  logic [6:0]              reg_addr,
  input  logic [63:0]             reg_wdata,
  output logic [63:0]             reg_rdata,
  output logic                    irq
);
  import pmu_pkg::*;

  localparam int NB   = NUM_CTR + 1;
  localparam int SUMW = DW + $clog2(NUM_SRC + 2);

  if (NUM_CTR > 31 || NUM_CTR < 1) begin : g_bad_cfg
    $error("pmu_top: NUM_CTR must lie in 1..31");
  end

  function automatic logic [31:0] ceid_calc();
    logic [31:0] m;
    m = 32'h0;
    m[EV_SOFT[4:0]]  = 1'b1;
    m[EV_CYCLE[4:0]] = 1'b1;
    for (int s = 0; s < NUM_SRC; s++)
      if (SRC_EVT[s*8 +: 8] < 8'h20) m[SRC_EVT[s*8 +: 5]] = 1'b1;
    return m;
  endfunction
  localparam logic [31:0] CEID = ceid_calc();

  logic          gen_q, div_q;
  logic [NB-1:0] cen_q, inten_q, ovf_q, wide_q;
  logic [7:0]    etype_q [NUM_CTR];
  logic [CW-1:0] val [NB];
  logic [NB-1:0] ovf_set;
  logic [NB-1:0] cnt_en;
  logic [5:0]    rem;
  logic          cyc_step;

  logic wr_ctrl, wr_cen, wr_ovf, wr_inten, wr_swinc, wr_wide, wr_cyc;
  assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
  assign wr_cen   = reg_we && reg_addr == A_CEN;
  assign wr_ovf   = reg_we && reg_addr == A_OVF;
  assign wr_inten = reg_we && reg_addr == A_INTEN;
  assign wr_swinc = reg_we && reg_addr == A_SWINC;
  assign wr_wide  = reg_we && reg_addr == A_WIDE;
  assign wr_cyc   = reg_we && reg_addr == A_CYC;

  assign cnt_en = {NB{gen_q}} & cen_q & ~ev_filtered;

  pmu_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_en    (div_q),
    .div_toggle(wr_ctrl && (reg_wdata[2] != div_q)),
    .tick      (cyc_tick & cnt_en[NUM_CTR]),
    .step      (cyc_step),
    .rem       (rem)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [6:0] VA = A_VAL  + 7'(i);
    localparam logic [6:0] TA = A_TYPE + 7'(i);
    logic [SUMW-1:0] dl;
    logic            tw;

    assign tw = reg_we && reg_addr == TA;

    pmu_evt_sel #(.NUM_SRC(NUM_SRC), .DW(DW), .SUMW(SUMW), .SRC_EVT(SRC_EVT)) u_sel (
      .evt_id   (etype_q[i]),
      .src_delta(ev_delta),
      .cyc_tick (cyc_tick),
      .sw_bit   (wr_swinc & reg_wdata[i]),
      .delta    (dl)
    );

    pmu_ctr #(.DLW(SUMW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_en(cnt_en[i]),
      .delta   (dl),
      .wide    (wide_q[i]),
      .wr_en   (reg_we && reg_addr == VA),
      .wr_val  (reg_wdata),
      .clr     (tw && (reg_wdata[7:0] != etype_q[i])),
      .value   (val[i]),
      .ovf_set (ovf_set[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)  etype_q[i] <= 8'h0;
      else if (tw) etype_q[i] <= reg_wdata[7:0];
    end
  end

  pmu_ctr #(.DLW(1)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_en(cnt_en[NUM_CTR]),
    .delta   (cyc_step),
    .wide    (wide_q[NUM_CTR]),
    .wr_en   (wr_cyc || (wr_ctrl && reg_wdata[1])),
    .wr_val  (wr_cyc ? reg_wdata : 64'h0),
    .clr     (1'b0),
    .value   (val[NUM_CTR]),
    .ovf_set (ovf_set[NUM_CTR])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q   <= 1'b0;
      div_q   <= 1'b0;
      cen_q   <= '0;
      inten_q <= '0;
      ovf_q   <= '0;
      wide_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        gen_q <= reg_wdata[0];
        div_q <= reg_wdata[2];
      end
      if (wr_cen)   cen_q   <= reg_wdata[NB-1:0];
      if (wr_inten) inten_q <= reg_wdata[NB-1:0];
      if (wr_wide)  wide_q  <= reg_wdata[NB-1:0];
      ovf_q <= (ovf_q & ~(wr_ovf ? reg_wdata[NB-1:0] : '0)) | ovf_set;
    end
  end

  assign irq = |(ovf_q & inten_q);

  always_comb begin
    reg_rdata = 64'h0;
    case (reg_addr)
      A_CTRL:    reg_rdata = {61'h0, div_q, 1'b0, gen_q};
      A_CEN:     reg_rdata = 64'(cen_q);
      A_OVF:     reg_rdata = 64'(ovf_q);
      A_INTEN:   reg_rdata = 64'(inten_q);
      A_WIDE:    reg_rdata = 64'(wide_q);
      A_CEID:    reg_rdata = {32'h0, CEID};
      A_CYC:     reg_rdata = val[NUM_CTR];
      A_CYC32:   reg_rdata = {32'h0, val[NUM_CTR][31:0]};
      A_CYCTYPE: reg_rdata = {56'h0, EV_CYCLE};
      default: begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (reg_addr == A_VAL + 7'(i))  reg_rdata = val[i];
          if (reg_addr == A_LO + 7'(i))   reg_rdata = {32'h0, val[i][31:0]};
          if (reg_addr == A_TYPE + 7'(i)) reg_rdata = {56'h0, etype_q[i]};
        end
      end
    endcase
  end
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk #(
  parameter int NB = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [6:0]    reg_addr,
  input logic          cyc_rst_bit,
  input logic          irq,
  input logic [NB-1:0] inten,
  input logic [NB-1:0] ovf,
  input logic          gen,
  input logic          div,
  input logic [5:0]    rem,
  input logic [63:0]   cyc_val,
  input logic [63:0]   val0
);
  import pmu_pkg::*;

  // R9: status bits are sticky unless a status write occurs
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_OVF) |=> ((ovf & $past(ovf)) == $past(ovf)));

  // R9: the interrupt needs at least one enable
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (inten != '0));

  // R11: cycle counter reset bit clears the counter
  assert_cyc_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && cyc_rst_bit) |=> (cyc_val == 64'h0));

  // R7: changing divide mode leaves the remainder empty
  assert_rem_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div != $past(div)) |-> (rem == 6'h0));

  // R2: with the global enable off and no write, counters hold
  assert_hold_cyc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !reg_we) |=> $stable(cyc_val));

  assert_hold_ctr0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !reg_we) |=> $stable(val0));
endmodule

bind pmu_top pmu_chk #(.NB(NUM_CTR + 1)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .cyc_rst_bit(reg_wdata[1]),
  .irq        (irq),
  .inten      (inten_q),
  .ovf        (ovf_q),
  .gen        (gen_q),
  .div        (div_q),
  .rem        (rem),
  .cyc_val    (val[NUM_CTR]),
  .val0       (val[0])
);

// File: tb/pmu_top_test.sv
module pmu_top_test;
  import pmu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NB = 5;
  localparam logic [7:0] SMAP [4] = '{8'h06, 8'h08, 8'h08, 8'h40};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_delta = '0;
  logic        cyc_tick = 1'b0;
  logic [4:0]  ev_filtered = '0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmu_top uut (
    .clk(clk), .rst_n(rst_n), .ev_delta(ev_delta), .cyc_tick(cyc_tick),
    .ev_filtered(ev_filtered), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  logic [63:0] m_val [NB];
  bit          m_skip [NB];
  logic [4:0]  m_ovf, m_inten, m_cen, m_wide;
  bit          m_gen, m_div;
  logic [7:0]  m_type [NC];
  logic [5:0]  m_rem;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_rd(logic [6:0] a);
    case (a)
      A_CTRL:    return {61'h0, m_div, 1'b0, m_gen};
      A_CEN:     return 64'(m_cen);
      A_OVF:     return 64'(m_ovf);
      A_INTEN:   return 64'(m_inten);
      A_WIDE:    return 64'(m_wide);
      A_CEID:    return 64'h0002_0141;
      A_CYC:     return m_val[4];
      A_CYC32:   return {32'h0, m_val[4][31:0]};
      A_CYCTYPE: return 64'h11;
      default: begin
        for (int i = 0; i < NC; i++) begin
          if (a == A_VAL + 7'(i))  return m_val[i];
          if (a == A_LO + 7'(i))   return {32'h0, m_val[i][31:0]};
          if (a == A_TYPE + 7'(i)) return {56'h0, m_type[i]};
        end
        return 64'h0;
      end
    endcase
  endfunction

  function automatic string tag_of(logic [6:0] a);
    if (a == A_CTRL || a == A_CEN) return "R2";
    if (a == A_OVF || a == A_WIDE) return "R8";
    if (a == A_INTEN) return "R9";
    if (a == A_SWINC) return "R5";
    if (a == A_CEID) return "R12";
    if (a == A_CYC || a == A_CYC32 || a == A_CYCTYPE) return "R6";
    if (a >= A_VAL && a < A_VAL + 7'(NC)) return "R3";
    if (a >= A_LO && a < A_LO + 7'(NC)) return "R8";
    if (a >= A_TYPE && a < A_TYPE + 7'(NC)) return "R4";
    return "R1";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_val[i] = '0; m_skip[i] = 0; end
    for (int i = 0; i < NC; i++) m_type[i] = '0;
    m_ovf = '0; m_inten = '0; m_cen = '0; m_wide = '0;
    m_gen = 0; m_div = 0; m_rem = '0;
  endtask

  task automatic step(bit we, logic [6:0] a, logic [63:0] d, logic [15:0] ev,
                      bit cy, logic [4:0] flt, string tag);
    logic [4:0]  en, setv, sw;
    logic [63:0] wv, room;
    int          dl;
    bit          wr, clr, tick, carry;
    string       t;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; ev_delta = ev; cyc_tick = cy; ev_filtered = flt;
    #1;
    t = (tag != "") ? tag : tag_of(a);
    if (!we) check(reg_rdata == model_rd(a), t, reg_rdata, model_rd(a));
    check(irq == |(m_ovf & m_inten), "R9 irq", 64'(irq), 64'(|(m_ovf & m_inten)));
    en = {5{m_gen}} & m_cen & ~flt;
    sw = (we && a == A_SWINC) ? {1'b0, d[3:0]} : 5'h0;
    setv = '0;
    tick = cy & en[4];
    carry = m_div ? (tick && m_rem == 6'h3f) : tick;
    for (int i = 0; i < NB; i++) begin
      dl = 0;
      if (i < NC) begin
        for (int s = 0; s < 4; s++) if (SMAP[s] == m_type[i]) dl += int'(ev[s*4 +: 4]);
        if (m_type[i] == 8'h11) dl += int'(cy);
        if (m_type[i] == 8'h00) dl += int'(sw[i]);
        wr = we && a == A_VAL + 7'(i);
        wv = d;
        clr = we && a == A_TYPE + 7'(i) && d[7:0] != m_type[i];
      end else begin
        dl = int'(carry);
        wr = we && (a == A_CYC || (a == A_CTRL && d[1]));
        wv = (a == A_CYC) ? d : 64'h0;
        clr = 0;
      end
      if (wr) begin
        m_val[i] = wv; m_skip[i] = 1;
      end else if (clr) begin
        m_val[i] = '0;
      end else if (en[i] && dl != 0) begin
        if (m_skip[i]) m_skip[i] = 0;
        else begin
          room = m_wide[i] ? ~m_val[i] : {32'h0, ~m_val[i][31:0]};
          if (64'(dl) > room) setv[i] = 1'b1;
          m_val[i] = m_val[i] + 64'(dl);
        end
      end
    end
    if (we && a == A_CTRL && d[2] != m_div) m_rem = '0;
    else if (m_div && tick) m_rem = m_rem + 6'd1;
    m_ovf = (m_ovf & ~((we && a == A_OVF) ? d[4:0] : 5'h0)) | setv;
    if (we) begin
      if (a == A_CTRL) begin m_gen = d[0]; m_div = d[2]; end
      if (a == A_CEN) m_cen = d[4:0];
      if (a == A_INTEN) m_inten = d[4:0];
      if (a == A_WIDE) m_wide = d[4:0];
      for (int i = 0; i < NC; i++) if (a == A_TYPE + 7'(i)) m_type[i] = d[7:0];
    end
    @(posedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [63:0] d);
    step(1, a, d, 16'h0, 0, 5'h0, "");
  endtask

  task automatic rd(logic [6:0] a, string tag);
    step(0, a, 64'h0, 16'h0, 0, 5'h0, tag);
  endtask

  function automatic logic [63:0] near_max();
    case ($urandom % 4)
      0: return 64'hFFFF_FFF0 + 64'($urandom % 16);
      1: return 64'hFFFF_FFFF_FFFF_FFF0 + 64'($urandom % 16);
      2: return 64'($urandom % 64);
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    rd(A_CTRL, "R1"); rd(A_OVF, "R1"); rd(A_CYC, "R1");
    rd(A_VAL, "R1"); rd(A_TYPE + 7'd2, "R1");
    rd(A_CEID, "R12");
    wr(A_CYCTYPE, 64'h05); rd(A_CYCTYPE, "R6");

    // R8/R10/R9: 32-bit overflow after a load
    wr(A_TYPE, 64'h06); wr(A_INTEN, 64'h1); wr(A_CEN, 64'h1f); wr(A_CTRL, 64'h1);
    wr(A_VAL, 64'hFFFF_FFFE);
    step(0, A_VAL, 0, 16'h0001, 0, 5'h0, "R10");
    rd(A_VAL, "R10");
    step(0, A_VAL, 0, 16'h0001, 0, 5'h0, "R10");
    step(0, A_VAL, 0, 16'h0002, 0, 5'h0, "R8");
    rd(A_OVF, "R8"); rd(A_LO, "R8");
    wr(A_OVF, 64'h1); rd(A_OVF, "R9");

    // R5: software increment
    wr(A_TYPE + 7'd1, 64'h00); wr(A_SWINC, 64'h3); rd(A_VAL + 7'd1, "R5");
    wr(A_SWINC, 64'h2); wr(A_SWINC, 64'h2); rd(A_VAL + 7'd1, "R5");

    // R7/R11: prescaled cycle counter
    wr(A_CTRL, 64'h7);
    for (int k = 0; k < 140; k++) step(0, A_CYC, 0, 16'h0, 1, 5'h0, "R7");
    wr(A_CTRL, 64'h3);
    rd(A_CYC, "R11");
    for (int k = 0; k < 4; k++) step(0, A_CYC, 0, 16'h0, 1, 5'h0, "R11");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [6:0]  a;
      logic [63:0] d;
      bit          we;
      logic [15:0] ev;
      logic [4:0]  flt;
      we = ($urandom % 100) < 25;
      d = 64'($urandom);
      case ($urandom % 11)
        0: begin a = A_CTRL; d = {61'h0, ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) != 0}; end
        1: a = A_CEN;
        2: a = A_OVF;
        3: a = A_INTEN;
        4: a = A_SWINC;
        5: a = A_WIDE;
        6: begin a = ($urandom % 2) ? A_CYC : A_CYC32; d = near_max(); end
        7: begin a = A_VAL + 7'($urandom % NC); d = near_max(); end
        8: begin
             logic [7:0] ids [7] = '{8'h00, 8'h06, 8'h08, 8'h11, 8'h13, 8'h40, 8'h22};
             a = A_TYPE + 7'($urandom % NC); d = 64'(ids[$urandom % 7]);
           end
        9: begin a = A_LO + 7'($urandom % NC); we = 0; end
        default: begin a = ($urandom % 2) ? A_CEID : A_CYCTYPE; end
      endcase
      ev = 16'($urandom) & 16'($urandom);
      flt = (($urandom % 8) == 0) ? 5'($urandom) : 5'h0;
      step(we, a, d, ev, ($urandom % 4) != 0, flt, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule